// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital controller for the winding phases of a current-regulated motor drive. Each phase turns its power driver on and keeps it on until an external sense comparator reports that the winding current has reached the reference from the DAC. The block then holds that driver off for a fixed off-time while the current recirculates, and then turns it on again. The off-time is chosen per step position from a 4-bit code. After every turn-on there is a short blanking window in which comparator trips are ignored, so that switching spikes cannot end the on-time.

There are two ways to run the phases. In the free-running mode each phase chops on its own. In the synchronous mode, which removes hold-state noise, every phase starts its on-time from a common period counter. A phase that trips early stays off until the next common start. A sleep input lets all windings coast. When sleep is released, a settle timer reports not-ready, and the drivers stay off until the timer runs out. The comparator, the DAC and the power stage are outside this block. All times are counted in system clock cycles, with CLK_MHZ cycles per microsecond.

Top module: `chop_ctrl`

## Requirements
- R1: While rst_ni is low, and after reset with sleep_i low, every bit of drive_o is 0 and ready_o is 1.
- R2: In free-running mode (sync_i=0), a phase with a nonzero magnitude that is awake turns its driver on one cycle after it is enabled. The driver stays on while trip_i is low. Once the blanking window has passed, a trip sampled on a clock edge turns the driver off at that edge.
- R3: For BLANK_US·CLK_MHZ cycles after each turn-on (50 cycles by default), trip_i is ignored. With trip_i held high, the on-time is exactly 50 cycles.
- R4: After a trip the driver stays off for exactly 7·CLK_MHZ + (code·5·CLK_MHZ)/15 cycles, with the integer quotient truncated. Here code is the 4-bit off_code_i field of that phase (phase k uses bits 4k+3..4k), sampled at the trip. With the defaults this is 350 cycles for code 0, 400 for code 3, 466 for code 7 and 600 for code 15.
- R5: In free-running mode, the driver turns on again in the cycle right after the off-time ends.
- R6: A phase whose magnitude field (mag_i bits 4k+3..4k) is zero keeps its driver off.
- R7: One cycle after sleep_i is sampled high, every driver is off and ready_o is 0.
- R8: After sleep_i falls, ready_o stays low for exactly SETTLE_US·CLK_MHZ cycles (5000 by default). While ready_o is low, every driver is off. Chopping resumes one cycle after ready_o rises.
- R9: In synchronous mode (sync_i=1), a driver turns on only on a common start. Common starts come once every PERIOD_US·CLK_MHZ cycles (1250 by default). All phases that are chopping turn on in the same cycle.
- R10: In synchronous mode, a phase whose off-time ends before the next common start stays off until that start. With trip_i held high, this gives a pattern of 50 cycles on and 1200 cycles off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Coast request; all drivers off |
| sync_i | input | 1 | 1: phases start on a common period; 0: phases chop on their own |
| trip_i | input | NPH | Sense comparator per phase; 1 = current at reference |
| mag_i | input | NPH*MAG_W | Magnitude per phase; zero keeps that phase off |
| off_code_i | input | NPH*CODE_W | Off-time code per phase, from the step position |
| drive_o | output | NPH | Driver enable per phase |
| ready_o | output | 1 | Low during sleep and during the settle time after wake |

## Verification
The checker covers the behaviour that holds on every cycle: the drivers stay off during sleep and while the block is not ready, a zero magnitude keeps its phase off, no turn-on lasts only a single cycle, and in synchronous mode a turn-on happens only after a common start. Other properties need whole sequences of stimulus, and only the bench scenarios can show them. These include the exact on-times and off-times for each code, trips ignored inside the blanking window, the 5000-cycle settle length, and the 50/1200 lockstep pattern that both phases follow in synchronous mode.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ON,
    PH_OFF,
    PH_WAIT
  } ph_state_e;

  // off-time in cycles: linear map of code 0..code_max onto min..min+span
  function automatic int unsigned off_len(input int unsigned code,
                                          input int unsigned min_c,
                                          input int unsigned span_c,
                                          input int unsigned code_max);
    return min_c + (code * span_c) / code_max;
  endfunction

endpackage

// File: rtl/chop_settle.sv
module chop_settle #(
  parameter int unsigned SETTLE_CYC = 5000,
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic ready_o,
  output logic coast_o
);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (sleep_i)     cnt_q <= SW'(SETTLE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
  assign coast_o = sleep_i || !ready_o;

endmodule

// File: rtl/chop_period.sv
module chop_period #(
  parameter int unsigned PERIOD_CYC = 1250,
  localparam int unsigned PW = $clog2(PERIOD_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic start_o
);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (cnt_q == PW'(PERIOD_CYC - 1)) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign start_o = sync_i && (cnt_q == '0);

endmodule

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
#(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned OFF_MIN   = 350,
  parameter int unsigned OFF_SPAN  = 250,
  localparam int unsigned CODE_MAX = (1 << CODE_W) - 1,
  localparam int unsigned CNT_MAX  = (OFF_MIN + OFF_SPAN > BLANK_CYC) ? OFF_MIN + OFF_SPAN : BLANK_CYC,
  localparam int unsigned CW       = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              coast_i,
  input  logic              sync_i,
  input  logic              start_i,
  input  logic              trip_i,
  input  logic              mag_nz_i,
  input  logic [CODE_W-1:0] off_code_i,
  output logic              drive_o
);

  ph_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] off_cyc;
  logic          go, may_start;

  assign go        = mag_nz_i && !coast_i;
  assign may_start = !sync_i || start_i;
  assign off_cyc   = CW'(off_len(32'(off_code_i), OFF_MIN, OFF_SPAN, CODE_MAX));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_IDLE, PH_WAIT: begin
        if (may_start) begin
          st_d  = PH_ON;
          cnt_d = CW'(BLANK_CYC - 1);
        end
      end
      PH_ON: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;  // blanking: trip ignored
        else if (trip_i) begin
          st_d  = PH_OFF;
          cnt_d = off_cyc - 1'b1;
        end
      end
      PH_OFF: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (may_start) begin
          st_d  = PH_ON;
          cnt_d = CW'(BLANK_CYC - 1);
        end else begin
          st_d = PH_WAIT;
        end
      end
      default: st_d = PH_IDLE;
    endcase
    if (!go) begin
      st_d  = PH_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign drive_o = (st_q == PH_ON);

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int unsigned NPH        = 2,
  parameter int unsigned MAG_W      = 4,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned CLK_MHZ    = 50,
  parameter int unsigned OFF_MIN_US = 7,
  parameter int unsigned OFF_MAX_US = 12,
  parameter int unsigned BLANK_US   = 1,
  parameter int unsigned SETTLE_US  = 100,
  parameter int unsigned PERIOD_US  = 25
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sleep_i,
  input  logic                    sync_i,
  input  logic [NPH-1:0]          trip_i,
  input  logic [NPH*MAG_W-1:0]    mag_i,
  input  logic [NPH*CODE_W-1:0]   off_code_i,
  output logic [NPH-1:0]          drive_o,
  output logic                    ready_o
);

  localparam int unsigned OFF_MIN_CYC = CLK_MHZ * OFF_MIN_US;
  localparam int unsigned OFF_SPN_CYC = CLK_MHZ * (OFF_MAX_US - OFF_MIN_US);
  localparam int unsigned BLANK_CYC   = CLK_MHZ * BLANK_US;
  localparam int unsigned SETTLE_CYC  = CLK_MHZ * SETTLE_US;
  localparam int unsigned PERIOD_CYC  = CLK_MHZ * PERIOD_US;

  logic coast_w;
  logic start_w;

  chop_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sleep_i (sleep_i),
    .ready_o (ready_o),
    .coast_o (coast_w)
  );

  chop_period #(.PERIOD_CYC(PERIOD_CYC)) u_period (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .start_o (start_w)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    chop_phase #(
      .CODE_W    (CODE_W),
      .BLANK_CYC (BLANK_CYC),
      .OFF_MIN   (OFF_MIN_CYC),
      .OFF_SPAN  (OFF_SPN_CYC)
    ) u_ph (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .coast_i    (coast_w),
      .sync_i     (sync_i),
      .start_i    (start_w),
      .trip_i     (trip_i[k]),
      .mag_nz_i   (|mag_i[k*MAG_W +: MAG_W]),
      .off_code_i (off_code_i[k*CODE_W +: CODE_W]),
      .drive_o    (drive_o[k])
    );
  end

endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int unsigned NPH   = 2,
  parameter int unsigned MAG_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sleep_i,
  input logic                 sync_i,
  input logic [NPH*MAG_W-1:0] mag_i,
  input logic [NPH-1:0]       drive_o,
  input logic                 ready_o,
  input logic                 start_w
);

  a_r7_sleep_coast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (drive_o == '0) && !ready_o);

  a_r7_not_ready_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i) |-> !ready_o);

  a_r8_off_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> drive_o == '0);

  for (genvar k = 0; k < NPH; k++) begin : g_chk
    a_r6_zero_mag_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mag_i[k*MAG_W +: MAG_W] == '0) |=> !drive_o[k]);

    a_r3_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drive_o[k]) |=> drive_o[k]);

    a_r9_common_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(sync_i) && $rose(drive_o[k])) |-> $past(start_w));
  end

endmodule

bind chop_ctrl chop_ctrl_chk #(.NPH(NPH), .MAG_W(MAG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sleep_i (sleep_i),
  .sync_i  (sync_i),
  .mag_i   (mag_i),
  .drive_o (drive_o),
  .ready_o (ready_o),
  .start_w (start_w)
);

// File: tb/sim_chop_ctrl.sv
module sim_chop_ctrl;
  localparam int NPH = 2;
  localparam int MAG_W = 4;
  localparam int CODE_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                  rst_ni;
  logic                  sleep_i, sync_i;
  logic [NPH-1:0]        trip_i;
  logic [NPH*MAG_W-1:0]  mag_i;
  logic [NPH*CODE_W-1:0] off_code_i;
  logic [NPH-1:0]        drive_o;
  logic                  ready_o;

  chop_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .sync_i(sync_i),
    .trip_i(trip_i), .mag_i(mag_i), .off_code_i(off_code_i),
    .drive_o(drive_o), .ready_o(ready_o)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_off(input int code);
    return 350 + (code * 250) / 15;
  endfunction

  // scoreboard of expected run lengths on drive_o[0]
  string eq[$];
  bit    el[$];
  int    ew[$];

  task automatic push(input string r, input bit l, input int w);
    eq.push_back(r); el.push_back(l); ew.push_back(w);
  endtask

  bit mon_en = 0, lock_en = 0;
  bit started = 0, cur = 0, prev = 0;
  int run = 0, lock_err = 0;

  always @(negedge clk) begin
    if (!mon_en) begin
      started = 0;
    end else if (!started) begin
      if (drive_o[0] && !prev) begin started = 1; cur = 1; run = 1; end
    end else if (drive_o[0] == cur) begin
      run++;
    end else begin
      if (ew.size() != 0) begin
        string r; bit l; int w;
        r = eq.pop_front(); l = el.pop_front(); w = ew.pop_front();
        if (l != cur) chk(r, int'(cur), int'(l));
        else          chk(r, run, w);
      end
      cur = drive_o[0];
      run = 1;
    end
    prev = drive_o[0];
    if (lock_en && drive_o[0] != drive_o[1]) lock_err++;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic drain();
    mon_en = 1;
    while (ew.size() != 0) @(negedge clk);
    mon_en = 0;
  endtask

  initial begin
    int codes[4] = '{0, 15, 3, 7};
    rst_ni = 0; sleep_i = 0; sync_i = 0; trip_i = '0; mag_i = '0; off_code_i = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset drive", int'(drive_o), 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    chk("R1 drive after reset", int'(drive_o), 0);
    chk("R1 ready after reset", int'(ready_o), 1);

    // R2 / R6: phase 0 enabled, phase 1 magnitude zero
    mag_i = {4'd0, 4'd5};
    @(negedge clk);
    chk("R2 turn-on", int'(drive_o[0]), 1);
    chk("R6 zero magnitude", int'(drive_o[1]), 0);
    repeat (300) @(negedge clk);
    chk("R2 held on without trip", int'(drive_o[0]), 1);
    trip_i = 2'b01;
    @(negedge clk);
    chk("R2 trip turns off", int'(drive_o[0]), 0);
    trip_i = '0;

    // R3: trip inside blanking window is ignored
    begin
      int k = 0;
      while (!drive_o[0] && k < 1000) begin @(negedge clk); k++; end
    end
    trip_i = 2'b01;
    repeat (20) @(negedge clk);
    trip_i = '0;
    repeat (40) @(negedge clk);
    chk("R3 blanked trip ignored", int'(drive_o[0]), 1);

    // R3 / R4 / R5: free-running chop with trip held high, several codes
    mag_i = {4'd3, 4'd5};
    trip_i = 2'b11;
    foreach (codes[i]) begin
      off_code_i = {4'd0, 4'(codes[i])};
      push("R3 on-time", 1'b1, 50);
      push("R4 off-time", 1'b0, exp_off(codes[i]));
      push("R5 re-enable on-time", 1'b1, 50);
      push("R4 off-time repeat", 1'b0, exp_off(codes[i]));
      drain();
    end

    // R9 / R10: synchronous mode
    off_code_i = {4'd0, 4'd15};
    sync_i = 1;
    repeat (1300) @(negedge clk);
    push("R9 sync on-time", 1'b1, 50);
    push("R10 sync off until start", 1'b0, 1200);
    push("R9 sync on-time", 1'b1, 50);
    push("R10 sync off until start", 1'b0, 1200);
    lock_err = 0;
    lock_en = 1;
    drain();
    lock_en = 0;
    chk("R9 phases in lockstep", lock_err, 0);
    sync_i = 0;

    // R7 / R8: sleep and settle
    trip_i = '0;
    repeat (10) @(negedge clk);
    chk("R2 both phases on", int'(drive_o), 3);
    sleep_i = 1;
    @(negedge clk);
    chk("R7 coast", int'(drive_o), 0);
    chk("R7 not ready", int'(ready_o), 0);
    repeat (100) @(negedge clk);
    sleep_i = 0;
    begin
      int k = 0, bad = 0;
      do begin
        @(negedge clk); k++;
        if (drive_o != '0) bad++;
      end while (!ready_o && k < 6000);
      chk("R8 settle cycles", k, 5000);
      chk("R8 drivers off while settling", bad, 0);
    end
    @(negedge clk);
    chk("R8 chop resumes", int'(drive_o), 3);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule